// File: doc/BRIEF.md
# Dual Prescaled Down-Counter Timer

This block holds two independent 16-bit down-counters, each reachable through a small memory-mapped register window. Each counter has a reload register, a readable live count, a control register and a write-only interrupt clear. Counting is gated by an external tick enable. A selectable prescaler divides that tick by 1, 16 or 256 before each decrement.

When a counter takes a step while at zero, it times out. It then sets its interrupt line and either reloads from its reload register (periodic mode) or wraps to 0xFFFF (free-running mode). Writing the reload register restarts the count at once. Changing the prescale setting while running keeps the live count and only changes the pace of later steps.

Accesses are single-cycle. Read data and the no-decode flag are combinational from the request. A write takes effect at the clock edge that ends the request cycle. Any offset that does not map to a register is answered with the no-decode flag, and such an access changes no state.

Top module: `dual_dtimer`

## Requirements
- R1: Only `req_addr[5:0]` is decoded. Bit 5 selects the channel (0 or 1). Offsets 0x0/0x4/0x8/0xC within a channel are registers. Any address with bit 4 set or with bits [1:0] nonzero (for example 0x10, 0x30, 0x1C, 0x02) raises `rsp_nodecode` and changes no state.
- R2: A write to offset 0x0 (reload) stores `req_wdata[15:0]`. A read returns it zero-extended. The same write sets the live count to that value on the next cycle and restarts the prescaler phase.
- R3: A read of offset 0x4 returns the live count zero-extended. A write to offset 0x4 raises `rsp_nodecode` and has no effect.
- R4: Offset 0x8 (control) stores `req_wdata[7:0]`, and a read returns it zero-extended.
- R5: A write to offset 0xC clears that channel's `irq` bit on the next cycle, unless a timeout happens in the same cycle, in which case `irq` stays set. A read of offset 0xC raises `rsp_nodecode`.
- R6: Control bit 7 is the enable. While it is 0 the count holds. Writing it from 0 to 1 restarts the prescaler phase so that counting starts at once.
- R7: Control bits [3:2] choose the step rate: 00 steps on every tick, 01 on every 16th tick, and 10 or 11 on every 256th tick, counted from the last prescaler restart. A change of these bits leaves the live count and the phase untouched.
- R8: A step taken at count 0 sets `irq`. When control bit 6 is 1 (periodic), the count reloads from the reload register. When bit 6 is 0 (free-running), it becomes 0xFFFF. A step at any other count decrements by one.
- R9: The prescaler advances and the count steps only in cycles where `tick` is 1 and the channel is enabled.
- R10: The two channels share no state. An access to one channel never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable pulse fed to both prescalers |
| req_valid | input | 1 | Access request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte offset within the timer window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, zero unless a decoded read |
| rsp_nodecode | output | 1 | Access does not map to a register |
| irq | output | 2 | Per-channel timeout interrupt flags |

## Verification
`rsp_rdata` and `rsp_nodecode` are due in the same cycle as the request, so the bench drives on the falling edge and samples just before the next rising edge. Every register write, count step, reload and interrupt change is due one cycle later, at the rising edge that ends the request cycle. The bench's model updates at that same edge, so the next cycle's sample is compared against it. Timeout effects show on `irq` one cycle after the step taken at zero, and the bench compares `irq` every cycle to catch an early or late flag.

// File: rtl/dt_pkg.sv
package dt_pkg;
    localparam int CNT_W    = 16;
    localparam int PRE_W    = 8;
    localparam int CTRL_W   = 8;
    localparam int EN_BIT   = 7;
    localparam int MODE_BIT = 6;
    localparam int PS_LSB   = 2;

    typedef struct packed {
        logic [CNT_W-1:0]  value;
        logic [CNT_W-1:0]  load;
        logic [CTRL_W-1:0] ctrl;
        logic [PRE_W-1:0]  pre;
        logic              irq;
    } chan_t;

    typedef enum logic [1:0] {
        RK_NONE,
        RK_LOAD,
        RK_VALUE,
        RK_CTRL
    } rd_kind_e;
endpackage

// File: rtl/dt_regdec.sv
module dt_regdec
    import dt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NCH    = 2
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output logic [NCH-1:0]    wr_load,
    output logic [NCH-1:0]    wr_ctrl,
    output logic [NCH-1:0]    wr_clr,
    output rd_kind_e          rd_kind,
    output logic [$clog2(NCH)-1:0] rd_ch,
    output logic              nodecode
);
    localparam int CH_W = $clog2(NCH);

    logic       fmt_ok;
    logic [1:0] reg_sel;

    always_comb begin
        rd_ch    = addr[ADDR_W-1 -: CH_W];
        reg_sel  = addr[3:2];
        fmt_ok   = !addr[4] && (addr[1:0] == 2'b00);
        nodecode = valid && (!fmt_ok
                             || ( write && reg_sel == 2'd1)
                             || (!write && reg_sel == 2'd3));
        rd_kind  = RK_NONE;
        if (valid && !write && fmt_ok) begin
            unique case (reg_sel)
                2'd0:    rd_kind = RK_LOAD;
                2'd1:    rd_kind = RK_VALUE;
                2'd2:    rd_kind = RK_CTRL;
                default: rd_kind = RK_NONE;
            endcase
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_wr
        logic hit;
        assign hit        = valid && write && fmt_ok && (rd_ch == CH_W'(g));
        assign wr_load[g] = hit && reg_sel == 2'd0;
        assign wr_ctrl[g] = hit && reg_sel == 2'd2;
        assign wr_clr[g]  = hit && reg_sel == 2'd3;
    end
endmodule

// File: rtl/dt_channel.sv
module dt_channel
    import dt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_load,
    input  logic              wr_ctrl,
    input  logic              wr_clr,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  load_o,
    output logic [CNT_W-1:0]  value_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              irq_o,
    output logic              expire_o
);
    chan_t             st_q, st_d;
    logic [PRE_W-1:0]  mask;
    logic              en, step, expire;
    logic              unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:CNT_W];

    always_comb begin
        unique case (st_q.ctrl[PS_LSB +: 2])
            2'b00:   mask = '0;
            2'b01:   mask = PRE_W'(15);
            default: mask = '1;
        endcase
        en     = st_q.ctrl[EN_BIT];
        step   = en && tick && ((st_q.pre & mask) == mask);
        expire = step && (st_q.value == '0);

        st_d = st_q;
        if (en && tick)
            st_d.pre = st_q.pre + 1'b1;
        if (wr_ctrl) begin
            st_d.ctrl = wdata[CTRL_W-1:0];
            if (wdata[EN_BIT] && !en)
                st_d.pre = '0;
        end
        if (wr_load) begin
            st_d.load  = wdata[CNT_W-1:0];
            st_d.value = wdata[CNT_W-1:0];
            st_d.pre   = '0;
        end else if (step) begin
            if (expire)
                st_d.value = st_q.ctrl[MODE_BIT] ? st_q.load : '1;
            else
                st_d.value = st_q.value - 1'b1;
        end
        if (expire)
            st_d.irq = 1'b1;
        else if (wr_clr)
            st_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign load_o   = st_q.load;
    assign value_o  = st_q.value;
    assign ctrl_o   = st_q.ctrl;
    assign irq_o    = st_q.irq;
    assign expire_o = expire;
endmodule

// File: rtl/dual_dtimer.sv
module dual_dtimer
    import dt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_nodecode,
    output logic [1:0]        irq
);
    localparam int NCH  = 2;
    localparam int CH_W = $clog2(NCH);

    logic [NCH-1:0]             wr_load, wr_ctrl, wr_clr, expire_w;
    logic [NCH-1:0][CNT_W-1:0]  load_w, value_w;
    logic [NCH-1:0][CTRL_W-1:0] ctrl_w;
    rd_kind_e                   rd_kind;
    logic [CH_W-1:0]            rd_ch;

    dt_regdec #(.ADDR_W(ADDR_W), .NCH(NCH)) u_dec (
        .valid    (req_valid),
        .write    (req_write),
        .addr     (req_addr),
        .wr_load  (wr_load),
        .wr_ctrl  (wr_ctrl),
        .wr_clr   (wr_clr),
        .rd_kind  (rd_kind),
        .rd_ch    (rd_ch),
        .nodecode (rsp_nodecode)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dt_channel #(.DATA_W(DATA_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .wr_load  (wr_load[g]),
            .wr_ctrl  (wr_ctrl[g]),
            .wr_clr   (wr_clr[g]),
            .wdata    (req_wdata),
            .load_o   (load_w[g]),
            .value_o  (value_w[g]),
            .ctrl_o   (ctrl_w[g]),
            .irq_o    (irq[g]),
            .expire_o (expire_w[g])
        );
    end

    always_comb begin
        unique case (rd_kind)
            RK_LOAD:  rsp_rdata = DATA_W'(load_w[rd_ch]);
            RK_VALUE: rsp_rdata = DATA_W'(value_w[rd_ch]);
            RK_CTRL:  rsp_rdata = DATA_W'(ctrl_w[rd_ch]);
            default:  rsp_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dt_chk.sv
module dt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        req_valid,
    input logic        req_write,
    input logic [5:0]  req_addr,
    input logic [31:0] req_wdata,
    input logic        rsp_nodecode,
    input logic [1:0]  irq,
    input logic [1:0]  expire,
    input logic [15:0] value0,
    input logic [7:0]  ctrl0
);
    logic ld0, clr0;
    assign ld0  = req_valid && req_write && req_addr == 6'h00;
    assign clr0 = req_valid && req_write && req_addr == 6'h0C;

    // R1
    reserved_nodecode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_addr[4] |-> rsp_nodecode);

    // R3
    value_wr_nodecode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && req_addr[3:0] == 4'h4 |-> rsp_nodecode);

    // R2
    load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld0 |=> value0 == $past(req_wdata[15:0]));

    // R6
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl0[7] && !ld0 |=> $stable(value0));

    // R9
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !ld0 |=> $stable(value0));

    // R8
    expire_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire[0] |=> irq[0]);

    // R5
    clear_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr0 && !expire[0] |=> !irq[0]);
endmodule

bind dual_dtimer dt_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .rsp_nodecode (rsp_nodecode),
    .irq          (irq),
    .expire       (expire_w),
    .value0       (value_w[0]),
    .ctrl0        (ctrl_w[0])
);

// File: tb/sim_dual_dtimer.sv
module sim_dual_dtimer;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_nodecode;
    logic [1:0]  irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [15:0] m_val  [2];
    logic [15:0] m_load [2];
    logic [7:0]  m_ctrl [2];
    logic [7:0]  m_pre  [2];
    logic        m_irq  [2];

    dual_dtimer u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_nodecode(rsp_nodecode), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic string tag_of(logic w, logic [5:0] a);
        if (a[4] || a[1:0] != 0) return "R1 unmapped";
        case (a[3:2])
            2'd0: return "R2 reload";
            2'd1: return w ? "R3 value write" : "R3 R6 R7 R8 R9 R10 live count";
            2'd2: return "R4 control";
            default: return "R5 clear";
        endcase
    endfunction

    task automatic exp_access(input logic w, input logic [5:0] a,
                              output logic [31:0] rd, output logic nd);
        int c = a[5];
        rd = '0;
        nd = 1'b0;
        if (a[4] || a[1:0] != 0) nd = 1'b1;
        else case (a[3:2])
            2'd0: if (!w) rd = {16'h0, m_load[c]};
            2'd1: if (w) nd = 1'b1; else rd = {16'h0, m_val[c]};
            2'd2: if (!w) rd = {24'h0, m_ctrl[c]};
            default: if (!w) nd = 1'b1;
        endcase
    endtask

    task automatic model_step(input logic v, w, input logic [5:0] a,
                              input logic [31:0] d, input logic tk);
        for (int c = 0; c < 2; c++) begin
            logic       hit, ld, cw, cl, en, stp, exp_t;
            logic [7:0] mask;
            hit = v && w && a[5] == c[0] && !a[4] && a[1:0] == 0;
            ld  = hit && a[3:2] == 2'd0;
            cw  = hit && a[3:2] == 2'd2;
            cl  = hit && a[3:2] == 2'd3;
            // R7 rate: 00 -> 1, 01 -> 16, 1x -> 256
            mask  = (m_ctrl[c][3:2] == 2'b00) ? 8'h00 :
                    (m_ctrl[c][3:2] == 2'b01) ? 8'h0F : 8'hFF;
            en    = m_ctrl[c][7];
            stp   = en && tk && ((m_pre[c] & mask) == mask);
            exp_t = stp && m_val[c] == 16'h0;
            if (exp_t) m_irq[c] = 1'b1;
            else if (cl) m_irq[c] = 1'b0;
            if (ld) begin
                m_val[c]  = d[15:0];
                m_load[c] = d[15:0];
                m_pre[c]  = 8'h0;
            end else begin
                if (stp) m_val[c] = exp_t ? (m_ctrl[c][6] ? m_load[c] : 16'hFFFF)
                                          : m_val[c] - 16'd1;
                if (en && tk) m_pre[c] = m_pre[c] + 8'd1;
                if (cw && d[7] && !en) m_pre[c] = 8'h0;
            end
            if (cw) m_ctrl[c] = d[7:0];
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, exp_v);
        tests++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic cyc(input logic v, w, input logic [5:0] a,
                       input logic [31:0] d, input logic tk);
        logic [31:0] erd;
        logic        end_;
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_wdata = d; tick = tk;
        #(CLK_P/2 - 1);
        if (v) begin
            exp_access(w, a, erd, end_);
            check({tag_of(w, a), " nodecode"}, {31'h0, rsp_nodecode}, {31'h0, end_});
            if (!w) check({tag_of(w, a), " rdata"}, rsp_rdata, erd);
        end
        check("R5 R8 irq", {30'h0, irq}, {30'h0, m_irq[1], m_irq[0]});
        @(posedge clk);
        model_step(v, w, a, d, tk);
    endtask

    task automatic rd(input logic [5:0] a, input logic tk);
        cyc(1'b1, 1'b0, a, 32'h0, tk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic tk);
        cyc(1'b1, 1'b1, a, d, tk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed = 32'd20240611;
        void'($urandom(seed));
        for (int c = 0; c < 2; c++) begin
            m_val[c] = '0; m_load[c] = '0; m_ctrl[c] = '0; m_pre[c] = '0; m_irq[c] = 1'b0;
        end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // reset state: R2 R3 R4
        rd(6'h00, 0); rd(6'h04, 0); rd(6'h08, 0);
        rd(6'h20, 0); rd(6'h24, 0); rd(6'h28, 0);

        // R2: upper bits dropped, count restarts from new value
        wr(6'h00, 32'hABCD_1234, 0);
        rd(6'h00, 0); rd(6'h04, 0);
        // R4: only low control byte kept
        wr(6'h08, 32'hFFFF_FF44, 1);
        rd(6'h08, 1);
        // R6: disabled channel holds its count under ticks
        rd(6'h04, 1); rd(6'h04, 1);

        // R1 R3 R5: no-decode offsets, no state change
        wr(6'h04, 32'h0000_0077, 1);
        rd(6'h0C, 0); rd(6'h10, 0); rd(6'h30, 0); rd(6'h1C, 0); rd(6'h02, 0);
        wr(6'h10, 32'hFFFF_FFFF, 1);
        wr(6'h31, 32'hFFFF_FFFF, 1);
        rd(6'h00, 0); rd(6'h04, 0);

        // R8 periodic: ch1 load 3, enable div1 periodic; R10: ch0 untouched
        wr(6'h20, 32'h3, 0);
        wr(6'h28, 32'hC0, 0);
        for (int i = 0; i < 9; i++) rd(6'h24, 1);
        rd(6'h04, 1);
        // R5 clear, then R9: no tick, count holds
        wr(6'h2C, 32'h0, 0);
        for (int i = 0; i < 3; i++) rd(6'h24, 0);

        // R8 free-running: wraps to 0xFFFF
        wr(6'h28, 32'h80, 0);
        wr(6'h20, 32'h1, 0);
        for (int i = 0; i < 4; i++) rd(6'h24, 1);

        // R7: ch0 divide by 16, then switch to 256 mid-run keeping count
        wr(6'h00, 32'h20, 0);
        wr(6'h08, 32'hC4, 0);
        for (int i = 0; i < 40; i++) rd(6'h04, 1);
        wr(6'h08, 32'hC8, 1);
        for (int i = 0; i < 300; i++) rd(6'h04, 1);
        wr(6'h08, 32'hCC, 1);
        rd(6'h04, 1); rd(6'h08, 0);

        // random mix
        for (int i = 0; i < 6000; i++) begin
            logic [5:0]  a;
            logic [31:0] d;
            logic        w, v, tk;
            v  = ($urandom % 8) != 0;
            w  = ($urandom % 3) == 0;
            tk = ($urandom % 4) != 0;
            if (($urandom % 10) == 0) a = 6'($urandom);
            else a = {1'($urandom), 1'b0, 2'($urandom), 2'b00};
            d = $urandom;
            if (w && a[3:2] == 2'd0 && !a[4]) d[15:0] = 16'($urandom % 40);
            if (w && a[3:2] == 2'd2 && !a[4] && ($urandom % 4) != 0) d[3:2] = 2'b00;
            cyc(v, w, a, d, tk);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule